// File: doc/BRIEF.md
# Translation Table Update Engine

This block owns a table of 64-bit address translation entries and applies update commands to it. A command carries an operation code, a window identifier, an I/O bus address, a value and a count. Four operations are accepted: a single put writes one entry, a fill writes one value into N consecutive entries, a list put reads N entries from memory and writes them into consecutive entries, and a get returns one stored entry. Every command ends with a one-cycle `done` pulse and a status code.

The entry index is the page-aligned bus address, less the window's bus offset, shifted right by the page shift. Multi-entry commands advance one page per entry and halt at the first entry whose index falls outside the table. List entries are fetched through a simple request/response read port and are stored in big-endian byte order.

The sequencer has the states S_IDLE, S_CHECK, S_STEP, S_FETCH, S_WAIT, S_READ and S_DONE. It has these transitions:
- S_IDLE to S_CHECK when a command is accepted.
- S_CHECK to S_DONE when a check rejects the command or the count is zero. S_CHECK goes to S_STEP for a put or a fill, to S_FETCH for a list put, and to S_READ for a get.
- S_STEP to S_DONE when the index is out of range or the last entry has been written. Otherwise S_STEP goes back to S_STEP for a fill and to S_FETCH for a list put.
- S_FETCH to S_WAIT.
- S_WAIT to S_STEP when a response arrives.
- S_READ to S_DONE.
- S_DONE to S_IDLE.

Top module: `xlat_table_updater`

## Requirements
- R1: After reset every table entry reads as zero, and `busy`, `done`, `status` and `rd_entry` are all zero.
- R2: A command whose identifier has any of bits 63:32 set, or whose low 32 bits differ from WIN_ID, ends with status 2 (parameter error) and writes nothing.
- R3: The bus address is first aligned down to a page boundary. The index is then (aligned address − BUS_OFFSET) >> PAGE_SHIFT. Address bits below the page size have no effect.
- R4: An index at or above ENTRIES, including an address below BUS_OFFSET, gives status 2 and writes nothing for that entry.
- R5: A put (op 0) writes the value into the indexed entry and ends with status 0.
- R6: A fill (op 2) writes the value into `count` consecutive entries. A count above ENTRIES is rejected with status 2 before any write.
- R7: In fill and list puts, the address advances by one page per entry and the command stops at the first out-of-range entry. Entries written before that point stay written, and the status is 2.
- R8: A list put (op 3) with a count above MAX_LIST, or with `cmd_value` bits below LIST_ALIGN not all zero, ends with status 2 and issues no memory request.
- R9: A list put requests addresses `cmd_value + 8*i` in order. In `mem_rsp_data`, the byte at address+k sits in bits 8k+7:8k. The entry stored is big-endian: the byte at offset 0 is most significant.
- R10: A get (op 1) places the indexed entry on `rd_entry` with status 0. An out-of-range get gives status 2 and leaves `rd_entry` unchanged.
- R11: `busy` is high from the cycle after a command is accepted until `done`. Commands offered while `busy` is high are ignored. `done` is a single-cycle pulse.
- R12: A fill or list put with a count of zero ends with status 0 and changes no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; clears the table |
| cmd_valid | input | 1 | Command offered; taken only while idle |
| cmd_op | input | 2 | 0 put, 1 get, 2 fill, 3 list put |
| cmd_win_id | input | 64 | Window identifier |
| cmd_ioba | input | 64 | I/O bus address of the first entry |
| cmd_value | input | 64 | Entry value (put, fill) or list address (list put) |
| cmd_count | input | 32 | Entry count for fill and list put |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | 0 success, 2 parameter error |
| rd_entry | output | 64 | Entry returned by the last successful get |
| mem_req | output | 1 | One-cycle read request |
| mem_addr | output | 64 | Read address, 8-byte aligned |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Read data, byte k at bits 8k+7:8k |

## Verification
Puts are tried at a page start, at an unaligned offset within a page, at the last valid index, one index past the end, and below the bus offset. These cases separate correct alignment and offset subtraction from off-by-one or wrap-around errors. Fills are tried fully in range, with a count above the table size, with a count of zero, and starting near the table end. The last case shows that writes stop at the first failure rather than being skipped or applied to all entries. List puts use a pattern in which every byte differs, so byte order and fetch order are both visible. They are also tried with an oversized count and with a misaligned list address, to confirm that no read is issued. A second command offered during a running fill shows that commands are ignored while busy.

// File: rtl/xtu_pkg.sv
package xtu_pkg;

    typedef enum logic [1:0] {
        OP_PUT  = 2'd0,
        OP_GET  = 2'd1,
        OP_FILL = 2'd2,
        OP_LIST = 2'd3
    } op_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CHECK,
        S_STEP,
        S_FETCH,
        S_WAIT,
        S_READ,
        S_DONE
    } state_e;

    localparam logic [1:0] STAT_OK    = 2'd0;
    localparam logic [1:0] STAT_PARAM = 2'd2;

endpackage

// File: rtl/xtu_index_calc.sv
module xtu_index_calc #(
    parameter int          ENTRIES    = 64,
    parameter int          PAGE_SHIFT = 12,
    parameter logic [63:0] BUS_OFFSET = 64'h0010_0000,
    localparam int         IDX_W      = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic [63:0]      bus_addr,
    output logic [IDX_W-1:0] idx,
    output logic             in_range
);
    localparam logic [63:0] PAGE_LOW = (64'd1 << PAGE_SHIFT) - 64'd1;

    logic [63:0] aligned;
    logic [63:0] rel;
    logic [63:0] page_no;
    logic        below;

    always_comb begin
        aligned  = bus_addr & ~PAGE_LOW;
        below    = aligned < BUS_OFFSET;
        rel      = aligned - BUS_OFFSET;
        page_no  = rel >> PAGE_SHIFT;
        in_range = !below && (page_no < 64'(ENTRIES));
        idx      = page_no[IDX_W-1:0];
    end
endmodule

// File: rtl/xtu_byte_order.sv
module xtu_byte_order #(
    parameter int  DATA_W = 64,
    localparam int NBYTES = DATA_W / 8
) (
    input  logic [DATA_W-1:0] lane_data,
    output logic [DATA_W-1:0] word_be
);
    for (genvar k = 0; k < NBYTES; k++) begin : g_byte
        assign word_be[8*(NBYTES-1-k) +: 8] = lane_data[8*k +: 8];
    end
endmodule

// File: rtl/xtu_table_store.sv
module xtu_table_store #(
    parameter int  ENTRIES = 64,
    parameter int  DATA_W  = 64,
    localparam int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] slot [ENTRIES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) slot[i] <= '0;
        end else if (wr_en) begin
            slot[wr_idx] <= wr_data;
        end
    end

    always_comb begin
        rd_data = '0;
        if (int'(rd_idx) < ENTRIES) rd_data = slot[rd_idx];
    end

    // R4: the sequencer only writes slots that exist
    p_wr_inside_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (int'(wr_idx) < ENTRIES));
endmodule

// File: rtl/xlat_table_updater.sv
module xlat_table_updater #(
    parameter int          ENTRIES    = 64,
    parameter int          PAGE_SHIFT = 12,
    parameter logic [63:0] BUS_OFFSET = 64'h0010_0000,
    parameter logic [31:0] WIN_ID     = 32'h0000_0A07,
    parameter int          MAX_LIST   = 512,
    parameter int          LIST_ALIGN = 12
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_valid,
    input  logic [1:0]  cmd_op,
    input  logic [63:0] cmd_win_id,
    input  logic [63:0] cmd_ioba,
    input  logic [63:0] cmd_value,
    input  logic [31:0] cmd_count,
    output logic        busy,
    output logic        done,
    output logic [1:0]  status,
    output logic [63:0] rd_entry,
    output logic        mem_req,
    output logic [63:0] mem_addr,
    input  logic        mem_rsp_valid,
    input  logic [63:0] mem_rsp_data
);
    import xtu_pkg::*;

    localparam int          IDX_W      = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam logic [63:0] PAGE_BYTES = 64'd1 << PAGE_SHIFT;
    localparam logic [63:0] WORD_BYTES = 64'd8;

    state_e      state, nxt;
    op_e         op_q;
    logic [63:0] id_q, addr_q, val_q, ptr_q, rd_q;
    logic [31:0] remain_q;
    logic        err_q;

    logic [IDX_W-1:0] idx;
    logic             idx_ok;
    logic [63:0]      tbl_rd, fetched;
    logic             wr_en, set_err, id_ok, list_bad;

    xtu_index_calc #(.ENTRIES(ENTRIES), .PAGE_SHIFT(PAGE_SHIFT), .BUS_OFFSET(BUS_OFFSET))
        u_idx (.bus_addr(addr_q), .idx(idx), .in_range(idx_ok));

    xtu_byte_order #(.DATA_W(64))
        u_swap (.lane_data(mem_rsp_data), .word_be(fetched));

    xtu_table_store #(.ENTRIES(ENTRIES), .DATA_W(64))
        u_tbl (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(idx),
               .wr_data(val_q), .rd_idx(idx), .rd_data(tbl_rd));

    assign id_ok    = (id_q[63:32] == 32'd0) && (id_q[31:0] == WIN_ID);
    assign list_bad = (remain_q > 32'(MAX_LIST)) || (val_q[LIST_ALIGN-1:0] != '0);

    // next-state and strobes
    always_comb begin
        nxt     = state;
        wr_en   = 1'b0;
        set_err = 1'b0;
        unique case (state)
            S_IDLE:  if (cmd_valid) nxt = S_CHECK;
            S_CHECK: begin
                if (!id_ok) begin
                    set_err = 1'b1;
                    nxt     = S_DONE;
                end else begin
                    unique case (op_q)
                        OP_PUT: nxt = S_STEP;
                        OP_GET: nxt = S_READ;
                        OP_FILL: begin
                            if (remain_q > 32'(ENTRIES)) begin
                                set_err = 1'b1;
                                nxt     = S_DONE;
                            end else if (remain_q == 32'd0) nxt = S_DONE;
                            else nxt = S_STEP;
                        end
                        OP_LIST: begin
                            if (list_bad) begin
                                set_err = 1'b1;
                                nxt     = S_DONE;
                            end else if (remain_q == 32'd0) nxt = S_DONE;
                            else nxt = S_FETCH;
                        end
                    endcase
                end
            end
            S_STEP: begin
                if (!idx_ok) begin
                    set_err = 1'b1;
                    nxt     = S_DONE;
                end else begin
                    wr_en = 1'b1;
                    if (remain_q == 32'd1)    nxt = S_DONE;
                    else if (op_q == OP_LIST) nxt = S_FETCH;
                    else                      nxt = S_STEP;
                end
            end
            S_FETCH: nxt = S_WAIT;
            S_WAIT:  if (mem_rsp_valid) nxt = S_STEP;
            S_READ: begin
                set_err = !idx_ok;
                nxt     = S_DONE;
            end
            S_DONE:  nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // command context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q     <= OP_PUT;
            id_q     <= '0;
            addr_q   <= '0;
            val_q    <= '0;
            ptr_q    <= '0;
            rd_q     <= '0;
            remain_q <= '0;
            err_q    <= 1'b0;
        end else begin
            if (set_err) err_q <= 1'b0 | 1'b1;
            unique case (state)
                S_IDLE: if (cmd_valid) begin
                    op_q     <= op_e'(cmd_op);
                    id_q     <= cmd_win_id;
                    addr_q   <= cmd_ioba;
                    val_q    <= cmd_value;
                    remain_q <= (op_e'(cmd_op) == OP_PUT) ? 32'd1 : cmd_count;
                    err_q    <= 1'b0;
                end
                S_CHECK: ptr_q <= val_q;
                S_STEP: if (wr_en) begin
                    addr_q   <= addr_q + PAGE_BYTES;
                    remain_q <= remain_q - 32'd1;
                end
                S_WAIT: if (mem_rsp_valid) begin
                    val_q <= fetched;
                    ptr_q <= ptr_q + WORD_BYTES;
                end
                S_READ: if (idx_ok) rd_q <= tbl_rd;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy     = (state != S_IDLE);
        done     = (state == S_DONE);
        mem_req  = (state == S_FETCH);
        mem_addr = ptr_q;
        status   = err_q ? STAT_PARAM : STAT_OK;
        rd_entry = rd_q;
    end

    // R11: done lasts one cycle and only while busy
    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_done_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);
    // R11: an idle engine neither writes nor reads memory
    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!wr_en && !mem_req));
    // R9: read requests are single-cycle and word-aligned
    p_req_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);
    p_req_aligned_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[2:0] == 3'd0));
    // R2: a foreign identifier never reaches a write
    p_id_no_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_CHECK && !id_ok) |=> (state == S_DONE && status == STAT_PARAM));
endmodule

// File: tb/test_xlat_table_updater.sv
module test_xlat_table_updater;
    localparam int          ENT  = 64;
    localparam logic [63:0] BOFF = 64'h0010_0000;
    localparam logic [63:0] WID  = 64'h0000_0A07;
    localparam logic [63:0] LBASE = 64'h0000_0000_0004_2000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = '0;
    logic [63:0] cmd_win_id = '0, cmd_ioba = '0, cmd_value = '0;
    logic [31:0] cmd_count = '0;
    logic        busy, done, mem_req;
    logic [1:0]  status;
    logic [63:0] rd_entry, mem_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_data = '0;

    int n_chk = 0, n_fail = 0, n_req = 0;
    logic        pend = 1'b0;
    logic [63:0] paddr = '0;

    always #5 clk = ~clk;

    xlat_table_updater i_xlat_table_updater (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_win_id(cmd_win_id), .cmd_ioba(cmd_ioba), .cmd_value(cmd_value),
        .cmd_count(cmd_count), .busy(busy), .done(done), .status(status),
        .rd_entry(rd_entry), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data));

    function automatic logic [7:0] mbyte(input logic [63:0] a);
        return a[7:0] ^ (a[15:8] * 8'd3) ^ 8'h3C;
    endfunction

    function automatic logic [63:0] lane_word(input logic [63:0] a);
        logic [63:0] w;
        for (int k = 0; k < 8; k++) w[8*k +: 8] = mbyte(a + 64'(k));
        return w;
    endfunction

    function automatic logic [63:0] be_word(input logic [63:0] a);
        logic [63:0] w;
        for (int k = 0; k < 8; k++) w[8*(7-k) +: 8] = mbyte(a + 64'(k));
        return w;
    endfunction

    function automatic logic [63:0] ioba_of(input int i);
        return BOFF + (64'(i) << 12);
    endfunction

    // memory responder: answers one cycle after a request
    always @(negedge clk) begin
        mem_rsp_valid <= 1'b0;
        if (pend) begin
            mem_rsp_valid <= 1'b1;
            mem_rsp_data  <= lane_word(paddr);
            pend          <= 1'b0;
        end
        if (mem_req) begin
            pend  <= 1'b1;
            paddr <= mem_addr;
            n_req <= n_req + 1;
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [1:0] op, input logic [63:0] id, input logic [63:0] ioba,
                         input logic [63:0] val, input logic [31:0] cnt);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_win_id = id;
        cmd_ioba = ioba; cmd_value = val; cmd_count = cnt;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic wait_done(output logic [1:0] st);
        int n = 0;
        while (done !== 1'b1 && n < 5000) begin
            @(negedge clk);
            n++;
        end
        if (n >= 5000) chk("R11 done timeout", 64'(n), 64'd0);
        st = status;
    endtask

    task automatic run(input logic [1:0] op, input logic [63:0] id, input logic [63:0] ioba,
                       input logic [63:0] val, input logic [31:0] cnt, output logic [1:0] st);
        issue(op, id, ioba, val, cnt);
        wait_done(st);
    endtask

    task automatic get(input int i, output logic [63:0] d);
        logic [1:0] st;
        run(2'd1, WID, ioba_of(i), 64'd0, 32'd0, st);
        chk("R10 get status", 64'(st), 64'd0);
        d = rd_entry;
    endtask

    task automatic t_reset;
        logic [63:0] d;
        chk("R1 busy", 64'(busy), 64'd0);
        chk("R1 done", 64'(done), 64'd0);
        chk("R1 status", 64'(status), 64'd0);
        chk("R1 rd_entry", rd_entry, 64'd0);
        get(5, d);
        chk("R1 entry cleared", d, 64'd0);
    endtask

    task automatic t_put;
        logic [1:0] st; logic [63:0] d;
        run(2'd0, WID, ioba_of(3), 64'hDEAD_BEEF_0000_1003, 32'd0, st);
        chk("R5 put status", 64'(st), 64'd0);
        get(3, d);
        chk("R5 put entry", d, 64'hDEAD_BEEF_0000_1003);
        run(2'd0, WID, ioba_of(7) + 64'h0ABC, 64'h7777, 32'd0, st);
        get(7, d);
        chk("R3 unaligned address", d, 64'h7777);
        run(2'd0, WID, ioba_of(ENT - 1), 64'h6363, 32'd0, st);
        get(ENT - 1, d);
        chk("R4 last index", d, 64'h6363);
    endtask

    task automatic t_range;
        logic [1:0] st; logic [63:0] d;
        run(2'd0, WID, ioba_of(ENT), 64'h1111, 32'd0, st);
        chk("R4 past end status", 64'(st), 64'd2);
        run(2'd0, WID, BOFF - 64'h1000, 64'h2222, 32'd0, st);
        chk("R4 below offset status", 64'(st), 64'd2);
        get(0, d);
        chk("R4 entry 0 untouched", d, 64'd0);
        d = rd_entry;
        run(2'd1, WID, ioba_of(ENT + 2), 64'd0, 32'd0, st);
        chk("R10 bad get status", 64'(st), 64'd2);
        chk("R10 rd_entry held", rd_entry, d);
    endtask

    task automatic t_ident;
        logic [1:0] st; logic [63:0] d;
        run(2'd0, WID | 64'h0000_0001_0000_0000, ioba_of(9), 64'h9999, 32'd0, st);
        chk("R2 upper bits status", 64'(st), 64'd2);
        run(2'd0, WID ^ 64'h1, ioba_of(9), 64'h9999, 32'd0, st);
        chk("R2 mismatch status", 64'(st), 64'd2);
        get(9, d);
        chk("R2 entry untouched", d, 64'd0);
    endtask

    task automatic t_fill;
        logic [1:0] st; logic [63:0] d;
        run(2'd2, WID, ioba_of(10), 64'hF1F1, 32'd4, st);
        chk("R6 fill status", 64'(st), 64'd0);
        for (int i = 10; i < 14; i++) begin
            get(i, d);
            chk("R6 fill entry", d, 64'hF1F1);
        end
        get(14, d);
        chk("R6 fill end", d, 64'd0);
        run(2'd2, WID, ioba_of(20), 64'hBAD, 32'(ENT + 1), st);
        chk("R6 oversize status", 64'(st), 64'd2);
        get(20, d);
        chk("R6 oversize no write", d, 64'd0);
        run(2'd2, WID, ioba_of(21), 64'hBAD, 32'd0, st);
        chk("R12 zero fill status", 64'(st), 64'd0);
        get(21, d);
        chk("R12 zero fill no write", d, 64'd0);
        run(2'd2, WID, ioba_of(ENT - 2), 64'hE0E0, 32'd4, st);
        chk("R7 stop status", 64'(st), 64'd2);
        get(ENT - 2, d);
        chk("R7 first written", d, 64'hE0E0);
        get(ENT - 1, d);
        chk("R7 second written", d, 64'hE0E0);
    endtask

    task automatic t_list;
        logic [1:0] st; logic [63:0] d; int r0;
        run(2'd3, WID, ioba_of(24), LBASE, 32'd3, st);
        chk("R9 list status", 64'(st), 64'd0);
        for (int i = 0; i < 3; i++) begin
            get(24 + i, d);
            chk("R9 list entry big-endian", d, be_word(LBASE + 64'(8 * i)));
        end
        r0 = n_req;
        run(2'd3, WID, ioba_of(30), LBASE, 32'd513, st);
        chk("R8 oversize status", 64'(st), 64'd2);
        run(2'd3, WID, ioba_of(30), LBASE + 64'h8, 32'd2, st);
        chk("R8 misaligned status", 64'(st), 64'd2);
        chk("R8 no requests", 64'(n_req - r0), 64'd0);
        run(2'd3, WID, ioba_of(30), LBASE, 32'd0, st);
        chk("R12 zero list status", 64'(st), 64'd0);
        get(30, d);
        chk("R8 R12 no write", d, 64'd0);
        run(2'd3, WID, ioba_of(ENT - 1), LBASE, 32'd2, st);
        chk("R7 list stop status", 64'(st), 64'd2);
        get(ENT - 1, d);
        chk("R7 list first written", d, be_word(LBASE));
    endtask

    task automatic t_busy;
        logic [1:0] st; logic [63:0] d;
        issue(2'd2, WID, ioba_of(32), 64'hC3C3, 32'd6);
        chk("R11 busy after accept", 64'(busy), 64'd1);
        issue(2'd0, WID, ioba_of(40), 64'h4040, 32'd0);
        wait_done(st);
        chk("R11 fill status", 64'(st), 64'd0);
        @(negedge clk);
        chk("R11 done single cycle", 64'(done), 64'd0);
        get(40, d);
        chk("R11 ignored command", d, 64'd0);
        get(37, d);
        chk("R11 fill completed", d, 64'hC3C3);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_put();
        t_range();
        t_ident();
        t_fill();
        t_list();
        t_busy();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule